// File: doc/BRIEF.md
# Banked ROM Mapper with On-Chip Nibble RAM

This block sits between a CPU bus and an external program ROM. It turns the 16-bit CPU address into a wider ROM address. The lower 16 KiB window always shows bank 0. The upper 16 KiB window shows whichever bank the software last selected from a 4-bit bank register. The block also contains a small RAM of 512 cells, each four bits wide, that the CPU reaches through the 8 KiB window at 0xA000–0xBFFF.

Software controls the block by writing into the lower ROM range, 0x0000–0x3FFF. Address bit 8 of such a write picks the register it lands in:

- Bit 8 clear: the RAM gate register.
- Bit 8 set: the bank register.

The RAM answers only while its gate is open. The RAM is narrow, so a read returns the stored nibble in the low half of the byte, with the high half driven to ones. The ROM data comes back on a separate input, and the block forwards it onto the CPU read bus.

Top module: `nm_mapper`

## Requirements
- R1: A write to 0x0000–0x3FFF with address bit 8 = 0 opens the RAM gate when the data byte is exactly 0x0A, and closes it for any other byte.
- R2: A write to 0x0000–0x3FFF with address bit 8 = 1 loads the bank register from data bits [3:0]. A value of 0 is stored as 1, and data bits [7:4] are ignored.
- R3: After reset the bank register holds 1 and the RAM gate is closed.
- R4: For an address in 0x4000–0x7FFF, romAddr = {bank, addr[13:0]}, and a read returns romData.
- R5: For an address in 0x0000–0x3FFF, romAddr = {0, addr[13:0]}, and a read returns romData.
- R6: With the gate open, a write in 0xA000–0xBFFF stores data bits [3:0], and a read there returns 0xF0 OR the stored nibble.
- R7: The RAM cell is selected by addr[8:0] alone, so the RAM window repeats every 512 bytes.
- R8: With the gate closed, RAM-window reads return 0xFF and RAM-window writes leave the cells unchanged.
- R9: Reads outside the ROM and RAM windows, and any cycle with cpuRd low, return 0xFF. Writes outside 0x0000–0x3FFF and 0xA000–0xBFFF change no state.
- R10: A register write changes only the register that address bit 8 selects. Bank writes leave the gate unchanged, and gate writes leave the bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | CPU address |
| cpuWdata | input | 8 | CPU write data |
| cpuRd | input | 1 | Read strobe |
| cpuWr | input | 1 | Write strobe, taken at the rising clock edge |
| cpuRdata | output | 8 | Read data (combinational) |
| romAddr | output | 18 | External ROM byte address |
| romData | input | 8 | Byte returned by the external ROM |

## Verification
Some rules hold on every cycle, and the assertions check them there:

- The bank register never holds zero.
- The ROM address the block drives matches the bank register and the incoming address.
- The gate follows each gate write.
- A closed gate forces 0xFF onto RAM reads.
- An open gate drives the high nibble of RAM reads to ones.
- The bank changes only on a bank write.

Other behaviour needs stored history, so only the bench scenarios can show it:

- A cell keeps its value through writes made while the gate is closed.
- Addresses 512 bytes apart reach the same cell.
- A written nibble comes back intact.

// File: rtl/nm_pkg.sv
package nm_pkg;

  // Read-data source chosen by the control for the current bus cycle
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,   // no read or unmapped address: all ones
    RD_ROM   = 2'd1,   // forward external ROM byte
    RD_RAM   = 2'd2,   // nibble RAM with forced upper nibble
    RD_SHUT  = 2'd3    // RAM window with gate closed: all ones
  } rdSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic   gateWr;    // write RAM gate register
    logic   gateVal;   // value to load into the gate
    logic   bankWr;    // write bank register
    logic   ramWr;     // write one RAM cell (already gated)
    logic   romHigh;   // switchable ROM window addressed
    rdSel_t rdSel;     // read-data source
  } nmStrobes_t;

  // Region codes taken from address bits [15:13]
  localparam logic [2:0] REG_ROM_LO0 = 3'b000;
  localparam logic [2:0] REG_ROM_LO1 = 3'b001;
  localparam logic [2:0] REG_ROM_HI0 = 3'b010;
  localparam logic [2:0] REG_ROM_HI1 = 3'b011;
  localparam logic [2:0] REG_RAM     = 3'b101;

  localparam logic [7:0] GATE_KEY = 8'h0A;

endpackage

// File: rtl/nm_ctrl.sv
module nm_ctrl
  import nm_pkg::*;
(
  input  logic [2:0]  addrRegion,  // cpuAddr[15:13]
  input  logic        addrSel,     // register selector address bit
  input  logic [7:0]  wdata,
  input  logic        rd,
  input  logic        wr,
  input  logic        gateOpen,
  output nmStrobes_t  strobes
);

  logic inLo;
  logic inHi;
  logic inRam;

  always_comb begin
    inLo  = (addrRegion == REG_ROM_LO0) || (addrRegion == REG_ROM_LO1);
    inHi  = (addrRegion == REG_ROM_HI0) || (addrRegion == REG_ROM_HI1);
    inRam = (addrRegion == REG_RAM);
  end

  always_comb begin
    strobes         = '0;
    strobes.romHigh = inHi;
    strobes.gateVal = (wdata == GATE_KEY);
    strobes.gateWr  = wr && inLo && !addrSel;
    strobes.bankWr  = wr && inLo && addrSel;
    strobes.ramWr   = wr && inRam && gateOpen;

    if (!rd) begin
      strobes.rdSel = RD_IDLE;
    end else if (inLo || inHi) begin
      strobes.rdSel = RD_ROM;
    end else if (inRam) begin
      strobes.rdSel = gateOpen ? RD_RAM : RD_SHUT;
    end else begin
      strobes.rdSel = RD_IDLE;
    end
  end

endmodule

// File: rtl/nm_datapath.sv
module nm_datapath
  import nm_pkg::*;
#(
  parameter int BANK_W    = 4,
  parameter int PAGE_W    = 14,
  parameter int RAM_DEPTH = 512,
  parameter int NIB_W     = 4,
  localparam int RAM_AW   = $clog2(RAM_DEPTH),
  localparam int ROM_AW   = BANK_W + PAGE_W,
  localparam int DATA_W   = 2 * NIB_W
)(
  input  logic               clk,
  input  logic               rstN,
  input  nmStrobes_t         strobes,
  input  logic [PAGE_W-1:0]  pageOff,
  input  logic [NIB_W-1:0]   wNib,
  input  logic [DATA_W-1:0]  romData,
  output logic [DATA_W-1:0]  rdata,
  output logic [ROM_AW-1:0]  romAddr,
  output logic [BANK_W-1:0]  bankQ,
  output logic               gateQ
);

  localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

  logic [NIB_W-1:0]  cells [RAM_DEPTH];
  logic [RAM_AW-1:0] cellIdx;
  logic [BANK_W-1:0] bankNext;

  assign cellIdx = pageOff[RAM_AW-1:0];

  // Bank register: a zero request is promoted to bank one
  always_comb begin
    bankNext = wNib[BANK_W-1:0];
    if (bankNext == '0) bankNext = BANK_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ <= BANK_ONE;
      gateQ <= 1'b0;
    end else begin
      if (strobes.bankWr) bankQ <= bankNext;
      if (strobes.gateWr) gateQ <= strobes.gateVal;
    end
  end

  // Nibble RAM, no reset
  always_ff @(posedge clk) begin
    if (strobes.ramWr) cells[cellIdx] <= wNib;
  end

  // ROM address: fixed bank zero low, switchable bank high
  always_comb begin
    if (strobes.romHigh) romAddr = {bankQ, pageOff};
    else                 romAddr = {{BANK_W{1'b0}}, pageOff};
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_ROM:  rdata = romData;
      RD_RAM:  rdata = {{NIB_W{1'b1}}, cells[cellIdx]};
      default: rdata = '1;
    endcase
  end

endmodule

// File: rtl/nm_mapper.sv
module nm_mapper
  import nm_pkg::*;
#(
  parameter int BANK_W    = 4,
  parameter int PAGE_W    = 14,
  parameter int RAM_DEPTH = 512,
  parameter int SEL_BIT   = 8,
  localparam int ROM_AW   = BANK_W + PAGE_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuWdata,
  input  logic              cpuRd,
  input  logic              cpuWr,
  output logic [7:0]        cpuRdata,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [7:0]        romData
);

  nmStrobes_t        strobes;
  logic [BANK_W-1:0] bankQ;
  logic              gateQ;

  nm_ctrl u_ctrl (
    .addrRegion (cpuAddr[15:13]),
    .addrSel    (cpuAddr[SEL_BIT]),
    .wdata      (cpuWdata),
    .rd         (cpuRd),
    .wr         (cpuWr),
    .gateOpen   (gateQ),
    .strobes    (strobes)
  );

  nm_datapath #(
    .BANK_W    (BANK_W),
    .PAGE_W    (PAGE_W),
    .RAM_DEPTH (RAM_DEPTH),
    .NIB_W     (4)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pageOff (cpuAddr[PAGE_W-1:0]),
    .wNib    (cpuWdata[3:0]),
    .romData (romData),
    .rdata   (cpuRdata),
    .romAddr (romAddr),
    .bankQ   (bankQ),
    .gateQ   (gateQ)
  );

endmodule

// File: rtl/nm_mapper_chk.sv
module nm_mapper_chk #(
  parameter int BANK_W = 4,
  parameter int PAGE_W = 14,
  localparam int ROM_AW = BANK_W + PAGE_W
)(
  input logic              clk,
  input logic              rstN,
  input logic [15:0]       cpuAddr,
  input logic [7:0]        cpuWdata,
  input logic              cpuRd,
  input logic              cpuWr,
  input logic [7:0]        cpuRdata,
  input logic [ROM_AW-1:0] romAddr,
  input logic [BANK_W-1:0] bankQ,
  input logic              gateQ
);

  logic isLo, isHi, isRam;
  assign isLo  = (cpuAddr[15:14] == 2'b00);
  assign isHi  = (cpuAddr[15:14] == 2'b01);
  assign isRam = (cpuAddr[15:13] == 3'b101);

  // R3
  a_r3_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (bankQ == BANK_W'(1)) && !gateQ);

  // R2
  a_r2_bank_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    bankQ != '0);

  // R1
  a_r1_gate_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && isLo && !cpuAddr[8]) |=> (gateQ == ($past(cpuWdata) == 8'h0A)));

  // R10
  a_r10_bank_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuWr && isLo && cpuAddr[8]) |=> $stable(bankQ));

  // R4
  a_r4_high_rom_addr: assert property (@(posedge clk) disable iff (!rstN)
    isHi |-> (romAddr == {bankQ, cpuAddr[PAGE_W-1:0]}));

  // R8
  a_r8_shut_reads_ones: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && isRam && !gateQ) |-> (cpuRdata == 8'hFF));

  // R6
  a_r6_upper_nibble: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && isRam && gateQ) |-> (cpuRdata[7:4] == 4'hF));

endmodule

bind nm_mapper nm_mapper_chk #(.BANK_W(BANK_W), .PAGE_W(PAGE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuAddr  (cpuAddr),
  .cpuWdata (cpuWdata),
  .cpuRd    (cpuRd),
  .cpuWr    (cpuWr),
  .cpuRdata (cpuRdata),
  .romAddr  (romAddr),
  .bankQ    (bankQ),
  .gateQ    (gateQ)
);

// File: tb/nm_mapper_bench.sv
module nm_mapper_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWdata = '0;
  logic        cpuRd = 1'b0;
  logic        cpuWr = 1'b0;
  logic [7:0]  cpuRdata;
  logic [17:0] romAddr;
  logic [7:0]  romData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  // External ROM model: byte derived from its address
  function automatic logic [7:0] romByte(input logic [17:0] a);
    return a[7:0] ^ {a[17:14], a[11:8]};
  endfunction
  assign romData = romByte(romAddr);

  nm_mapper u_nm_mapper (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuRdata(cpuRdata),
    .romAddr(romAddr), .romData(romData)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWdata = d; cpuWr = 1'b1; cpuRd = 1'b0;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic busRead(input logic [15:0] a, output logic [7:0] d, output logic [17:0] ra);
    @(negedge clk);
    cpuAddr = a; cpuRd = 1'b1; cpuWr = 1'b0;
    #1;
    d = cpuRdata; ra = romAddr;
    @(negedge clk);
    cpuRd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic [17:0] ra;
    busRead(16'h4000, d, ra);
    check("R3 bank after reset", ra, {4'd1, 14'h0000});
    busRead(16'hA000, d, ra);
    check("R3 gate closed after reset", d, 8'hFF);
  endtask

  task automatic t_bank;
    logic [7:0] d; logic [17:0] ra;
    busWrite(16'h2100, 8'h05);
    busRead(16'h4123, d, ra);
    check("R4 high rom addr", ra, {4'd5, 14'h0123});
    check("R4 high rom data", d, romByte({4'd5, 14'h0123}));
    busWrite(16'h2100, 8'h00);
    busRead(16'h7FFF, d, ra);
    check("R2 zero becomes one", ra, {4'd1, 14'h3FFF});
    busWrite(16'h31FF, 8'hF7);
    busRead(16'h5000, d, ra);
    check("R2 upper data bits ignored", ra, {4'd7, 14'h1000});
    busWrite(16'h2000, 8'h03);  // bit 8 clear: gate write
    busRead(16'h4000, d, ra);
    check("R10 gate write keeps bank", ra, {4'd7, 14'h0000});
  endtask

  task automatic t_ram;
    logic [7:0] d; logic [17:0] ra;
    busWrite(16'h0000, 8'h0A);
    busWrite(16'hA000, 8'h3C);
    busRead(16'hA000, d, ra);
    check("R6 nibble readback", d, 8'hFC);
    busWrite(16'h0000, 8'h1A);
    busRead(16'hA000, d, ra);
    check("R1 non-key byte closes gate", d, 8'hFF);
    busWrite(16'hA000, 8'h05);
    busWrite(16'h0000, 8'h0A);
    busRead(16'hA000, d, ra);
    check("R8 write while shut ignored", d, 8'hFC);
    busWrite(16'h0100, 8'h0A);  // bit 8 set: bank write
    busRead(16'hA000, d, ra);
    check("R10 bank write keeps gate", d, 8'hFC);
    busRead(16'h4000, d, ra);
    check("R10 bank write took 0x0A", ra, {4'd10, 14'h0000});
  endtask

  task automatic t_mirror;
    logic [7:0] d; logic [17:0] ra;
    busWrite(16'hA1FF, 8'h07);
    busRead(16'hB3FF, d, ra);
    check("R7 mirror of last cell", d, 8'hF7);
    busWrite(16'hA200, 8'h09);
    busRead(16'hA000, d, ra);
    check("R7 mirror overwrites cell 0", d, 8'hF9);
  endtask

  task automatic t_lower;
    logic [7:0] d; logic [17:0] ra;
    busRead(16'h1234, d, ra);
    check("R5 low rom addr", ra, 18'h01234);
    check("R5 low rom data", d, romByte(18'h01234));
  endtask

  task automatic t_unmapped;
    logic [7:0] d; logic [17:0] ra;
    busRead(16'h8000, d, ra);
    check("R9 video range reads ones", d, 8'hFF);
    busRead(16'hC000, d, ra);
    check("R9 high range reads ones", d, 8'hFF);
    busWrite(16'h6000, 8'h00);
    busWrite(16'hC100, 8'h0A);
    busRead(16'h4000, d, ra);
    check("R9 stray writes keep bank", ra, {4'd10, 14'h0000});
    @(negedge clk);
    cpuAddr = 16'h1000; cpuRd = 1'b0;
    #1;
    check("R9 idle bus reads ones", cpuRdata, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_bank();
    t_ram();
    t_mirror();
    t_lower();
    t_unmapped();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule